// File: doc/BRIEF.md
# Real-FFT Unpack Stage

This block lets an N-point complex FFT core produce the spectrum of a 2N-point real sequence. A small front end packs the real stream for the core. Each even-numbered sample becomes the real part of a complex word, and the odd sample after it becomes the imaginary part. The core itself sits outside the block. Its N output bins come back into the unpack stage in natural order.

The unpack stage stores each frame of N bins in one of two banks. While the next frame is written into the other bank, it reads the stored bins in pairs: bin k and its partner (N-k) mod N, so bin 0 pairs with itself. From each pair it forms the spectra of the even and odd samples. It rotates the odd spectrum by the half-rate twiddle exp(-j·πk/N) and adds the two, which gives G(k) for k = 0..N-1. The upper mirrored half of the spectrum is not produced.

Top module: `rfft_unpack`

## Requirements
- R1: Accepted real samples (smpValid high) pair up in arrival order. The first sample of a pair goes out as pkRe and the second as pkIm, with pkValid high for the one cycle after the clock edge that accepts the second sample. pkLast is high on the N-th pair of each group and on no other pair. pkValid is never high on two consecutive cycles.
- R2: Each accepted bin (binValid high) is stored at the next index in 0..N-1. Idle cycles between bins have no effect. A frame closes when the bin at index N-1 is accepted, whatever the state of binLast.
- R3: If binLast is high on an accepted bin whose index is below N-1, the partial frame is discarded. No output is produced for it, and the next accepted bin is stored at index 0.
- R4: After a frame closes, G(0)..G(N-1) leave in natural order on N consecutive cycles. gValid first rises two clock edges after the edge that accepted the closing bin. gLast is high only with G(N-1).
- R5: Bin k is paired with bin (N-k) mod N, and bin 0 is paired with itself. With integer bins, G(0) therefore equals Re X(0) + Im X(0) on the real part and 0 on the imaginary part.
- R6: With A = X(k) and B = X((N-k) mod N), the block computes X1 = ((Ar+Br)>>>1, (Ai-Bi)>>>1) and X2 = ((Ai+Bi)>>>1, (Br-Ar)>>>1). It uses c = round(cos(πk/N)·2^14) and s = round(sin(πk/N)·2^14), rounding half away from zero. The output is G = (X1r + ((c·X2r + s·X2i)>>>14), X1i + ((c·X2i - s·X2r)>>>14)) on 18-bit signed outputs. Every >>> is a floor shift, and the result is exact for all 16-bit inputs, including -32768.
- R7: A new frame may arrive while the previous one is being read. Frames sent back to back with no idle cycles produce output streams back to back, with no gap and no corruption of either frame.
- R8: While rst is high and on the first cycle after it, gValid, gLast, pkValid and pkLast are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smpValid | input | 1 | Real sample present |
| smpData | input | 16 | Real sample, signed |
| pkValid | output | 1 | Packed complex word present |
| pkRe | output | 16 | Packed real part (even sample) |
| pkIm | output | 16 | Packed imaginary part (odd sample) |
| pkLast | output | 1 | Last packed word of an N-word group |
| binValid | input | 1 | FFT bin present |
| binLast | input | 1 | Frame end marker from the FFT core |
| binRe | input | 16 | FFT bin real part, signed |
| binIm | input | 16 | FFT bin imaginary part, signed |
| gValid | output | 1 | Output bin present |
| gLast | output | 1 | Output bin N-1 |
| gRe | output | 18 | G(k) real part, signed |
| gIm | output | 18 | G(k) imaginary part, signed |

## Verification
Each port is checked on every cycle. A fault in the write index, the partner computation or the bank select does not stay hidden in storage. It corrupts G values of the frame being read, and the first bad G(k) appears two cycles after that bin's read slot. A swapped or shared bank shows up only when frames overlap, so back-to-back frames and frames with idle cycles between bins are both driven. A wrong twiddle entry, shift or sign shows as a miscompare at the affected k. Full-scale inputs bring out any overflow in the sums.

// File: rtl/rfu_pkg.sv
package rfu_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic wrEn;    // store incoming bin
    logic wrBank;  // bank receiving bins
    logic rdEn;    // read slot active
    logic rdBank;  // bank being unpacked
    logic rdLast;  // current read slot is k = N-1
  } rfu_strobe_t;

endpackage

// File: rtl/rfu_packer.sv
module rfu_packer #(
  parameter int N      = 16,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     smpValid,
  input  logic signed [DATA_W-1:0] smpData,
  output logic                     pkValid,
  output logic signed [DATA_W-1:0] pkRe,
  output logic signed [DATA_W-1:0] pkIm,
  output logic                     pkLast
);
  localparam int IDX_W = $clog2(N);
  localparam logic [IDX_W-1:0] LAST_PAIR = IDX_W'(N - 1);

  logic                     haveEven;
  logic signed [DATA_W-1:0] evenReg;
  logic [IDX_W-1:0]         pairIdx;

  always_ff @(posedge clk) begin
    if (rst) begin
      haveEven <= 1'b0;
      evenReg  <= '0;
      pairIdx  <= '0;
      pkValid  <= 1'b0;
      pkLast   <= 1'b0;
      pkRe     <= '0;
      pkIm     <= '0;
    end else begin
      pkValid <= 1'b0;
      pkLast  <= 1'b0;
      if (smpValid) begin
        if (!haveEven) begin
          evenReg  <= smpData;
          haveEven <= 1'b1;
        end else begin
          pkRe     <= evenReg;
          pkIm     <= smpData;
          pkValid  <= 1'b1;
          pkLast   <= (pairIdx == LAST_PAIR);
          pairIdx  <= pairIdx + 1'b1;
          haveEven <= 1'b0;
        end
      end
    end
  end

  AST_PK_SPACED: assert property (@(posedge clk) disable iff (rst)
    pkValid |=> !pkValid); // R1

  AST_PK_LAST_QUAL: assert property (@(posedge clk) disable iff (rst)
    pkLast |-> pkValid); // R1

endmodule

// File: rtl/rfu_ctrl.sv
module rfu_ctrl
  import rfu_pkg::*;
#(
  parameter int N = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inValid,
  input  logic                     inLast,
  output rfu_strobe_t              strobe,
  output logic [$clog2(N)-1:0]     wrIdx,
  output logic [$clog2(N)-1:0]     rdIdx
);
  localparam int IDX_W = $clog2(N);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N - 1);

  logic wrBank;
  logic rdActive;
  logic rdBank;
  logic frameClose;
  logic frameAbort;

  assign frameClose = inValid && (wrIdx == LAST_IDX);
  assign frameAbort = inValid && inLast && (wrIdx != LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      wrIdx    <= '0;
      wrBank   <= 1'b0;
      rdActive <= 1'b0;
      rdIdx    <= '0;
      rdBank   <= 1'b0;
    end else begin
      // read sweep
      if (rdActive) begin
        if (rdIdx == LAST_IDX) rdActive <= 1'b0;
        else                   rdIdx    <= rdIdx + 1'b1;
      end
      // write side; a closing frame overrides the sweep end
      if (frameAbort) begin
        wrIdx <= '0;
      end else if (frameClose) begin
        wrIdx    <= '0;
        wrBank   <= ~wrBank;
        rdActive <= 1'b1;
        rdIdx    <= '0;
        rdBank   <= wrBank;
      end else if (inValid) begin
        wrIdx <= wrIdx + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.wrEn   = inValid;
    strobe.wrBank = wrBank;
    strobe.rdEn   = rdActive;
    strobe.rdBank = rdBank;
    strobe.rdLast = rdActive && (rdIdx == LAST_IDX);
  end

  AST_PINGPONG: assert property (@(posedge clk) disable iff (rst)
    strobe.rdEn && strobe.wrEn |-> strobe.rdBank != strobe.wrBank); // R7

  AST_ABORT_REWIND: assert property (@(posedge clk) disable iff (rst)
    inValid && inLast && wrIdx != LAST_IDX |=> wrIdx == '0); // R3

  AST_CLOSE_STARTS_READ: assert property (@(posedge clk) disable iff (rst)
    inValid && wrIdx == LAST_IDX |=> strobe.rdEn && rdIdx == '0); // R2

  AST_READ_RUN: assert property (@(posedge clk) disable iff (rst)
    strobe.rdEn && !strobe.rdLast |=> strobe.rdEn && rdIdx == IDX_W'($past(rdIdx) + 1'b1)); // R4

endmodule

// File: rtl/rfu_datapath.sv
module rfu_datapath
  import rfu_pkg::*;
#(
  parameter int N      = 16,
  parameter int DATA_W = 16,
  parameter int COEF_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  rfu_strobe_t                strobe,
  input  logic [$clog2(N)-1:0]       wrIdx,
  input  logic [$clog2(N)-1:0]       rdIdx,
  input  logic signed [DATA_W-1:0]   binRe,
  input  logic signed [DATA_W-1:0]   binIm,
  output logic                       outValid,
  output logic                       outLast,
  output logic signed [DATA_W+1:0]   outRe,
  output logic signed [DATA_W+1:0]   outIm
);
  localparam int  IDX_W = $clog2(N);
  localparam int  OUT_W = DATA_W + 2;
  localparam int  SUM_W = DATA_W + 1;
  localparam int  FRAC  = COEF_W - 2;
  localparam int  PW    = COEF_W + DATA_W + 1;
  localparam real PI_R  = 3.14159265358979323846;

  function automatic logic signed [COEF_W-1:0] twCoef(input int k, input bit wantSin);
    real ang;
    real v;
    ang = PI_R * real'(k) / real'(N);
    v   = wantSin ? $sin(ang) : $cos(ang);
    v   = v * real'(1 << FRAC);
    return COEF_W'($rtoi(v >= 0.0 ? v + 0.5 : v - 0.5));
  endfunction

  // ---------------- twiddle table, built at elaboration
  logic signed [COEF_W-1:0] cosTab [N];
  logic signed [COEF_W-1:0] sinTab [N];

  for (genvar i = 0; i < N; i++) begin : g_tw
    localparam logic signed [COEF_W-1:0] COS_K = twCoef(i, 1'b0);
    localparam logic signed [COEF_W-1:0] SIN_K = twCoef(i, 1'b1);
    assign cosTab[i] = COS_K;
    assign sinTab[i] = SIN_K;
  end

  // ---------------- ping-pong bin banks
  logic signed [DATA_W-1:0] memRe [2][N];
  logic signed [DATA_W-1:0] memIm [2][N];

  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      memRe[strobe.wrBank][wrIdx] <= binRe;
      memIm[strobe.wrBank][wrIdx] <= binIm;
    end
  end

  // ---------------- forward and shifted-reversed read
  logic [IDX_W-1:0]         partner;
  logic signed [DATA_W-1:0] aRe, aIm, bRe, bIm;
  logic signed [SUM_W-1:0]  sumRe, difIm, sumIm, negRe;

  always_comb begin
    partner = IDX_W'(N) - rdIdx;
    aRe = memRe[strobe.rdBank][rdIdx];
    aIm = memIm[strobe.rdBank][rdIdx];
    bRe = memRe[strobe.rdBank][partner];
    bIm = memIm[strobe.rdBank][partner];
    sumRe = SUM_W'(aRe) + SUM_W'(bRe);
    difIm = SUM_W'(aIm) - SUM_W'(bIm);
    sumIm = SUM_W'(aIm) + SUM_W'(bIm);
    negRe = SUM_W'(bRe) - SUM_W'(aRe);
  end

  // ---------------- stage 1: even / odd split
  logic                     v1, l1;
  logic [IDX_W-1:0]         k1;
  logic signed [DATA_W-1:0] x1Re, x1Im, x2Re, x2Im;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      l1 <= 1'b0;
      k1 <= '0;
      x1Re <= '0; x1Im <= '0; x2Re <= '0; x2Im <= '0;
    end else begin
      v1 <= strobe.rdEn;
      l1 <= strobe.rdLast;
      k1 <= rdIdx;
      x1Re <= DATA_W'(sumRe >>> 1);
      x1Im <= DATA_W'(difIm >>> 1);
      x2Re <= DATA_W'(sumIm >>> 1);   // (D)/(2j): real <- imag
      x2Im <= DATA_W'(negRe >>> 1);   // imag <- -real
    end
  end

  // ---------------- stage 2: twiddle and merge
  logic signed [COEF_W-1:0] cK, sK;
  logic signed [PW-1:0]     accRe, accIm;
  logic signed [OUT_W-1:0]  tRe, tIm;

  always_comb begin
    cK    = cosTab[k1];
    sK    = sinTab[k1];
    accRe = PW'(cK) * PW'(x2Re) + PW'(sK) * PW'(x2Im);
    accIm = PW'(cK) * PW'(x2Im) - PW'(sK) * PW'(x2Re);
    tRe   = OUT_W'(accRe >>> FRAC);
    tIm   = OUT_W'(accIm >>> FRAC);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outLast  <= 1'b0;
      outRe    <= '0;
      outIm    <= '0;
    end else begin
      outValid <= v1;
      outLast  <= l1;
      outRe    <= OUT_W'(x1Re) + tRe;
      outIm    <= OUT_W'(x1Im) + tIm;
    end
  end

  AST_OUT_PIPE: assert property (@(posedge clk) disable iff (rst)
    outValid == $past(strobe.rdEn, 2)); // R4

  AST_LAST_QUAL: assert property (@(posedge clk) disable iff (rst)
    outLast |-> outValid); // R4

  AST_DC_BIN_REAL: assert property (@(posedge clk) disable iff (rst)
    $past(strobe.rdEn && rdIdx == '0, 2) |-> outIm == '0); // R5

endmodule

// File: rtl/rfft_unpack.sv
module rfft_unpack
  import rfu_pkg::*;
#(
  parameter int N      = 16,
  parameter int DATA_W = 16,
  parameter int COEF_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     smpValid,
  input  logic signed [DATA_W-1:0] smpData,
  output logic                     pkValid,
  output logic signed [DATA_W-1:0] pkRe,
  output logic signed [DATA_W-1:0] pkIm,
  output logic                     pkLast,
  input  logic                     binValid,
  input  logic                     binLast,
  input  logic signed [DATA_W-1:0] binRe,
  input  logic signed [DATA_W-1:0] binIm,
  output logic                     gValid,
  output logic                     gLast,
  output logic signed [DATA_W+1:0] gRe,
  output logic signed [DATA_W+1:0] gIm
);
  localparam int IDX_W = $clog2(N);

  rfu_strobe_t      strobe;
  logic [IDX_W-1:0] wrIdx;
  logic [IDX_W-1:0] rdIdx;

  rfu_packer #(.N(N), .DATA_W(DATA_W)) u_packer (
    .clk(clk), .rst(rst),
    .smpValid(smpValid), .smpData(smpData),
    .pkValid(pkValid), .pkRe(pkRe), .pkIm(pkIm), .pkLast(pkLast)
  );

  rfu_ctrl #(.N(N)) u_ctrl (
    .clk(clk), .rst(rst),
    .inValid(binValid), .inLast(binLast),
    .strobe(strobe), .wrIdx(wrIdx), .rdIdx(rdIdx)
  );

  rfu_datapath #(.N(N), .DATA_W(DATA_W), .COEF_W(COEF_W)) u_dp (
    .clk(clk), .rst(rst),
    .strobe(strobe), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .binRe(binRe), .binIm(binIm),
    .outValid(gValid), .outLast(gLast), .outRe(gRe), .outIm(gIm)
  );

endmodule

// File: tb/rfft_unpack_test.sv
`timescale 1ns/1ps
module rfft_unpack_test;
  localparam int N = 16;
  localparam int WD_LIMIT = 20000;
  localparam real PI_R = 3.14159265358979323846;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smpValid = 1'b0;
  logic signed [15:0] smpData = '0;
  logic pkValid, pkLast;
  logic signed [15:0] pkRe, pkIm;
  logic binValid = 1'b0, binLast = 1'b0;
  logic signed [15:0] binRe = '0, binIm = '0;
  logic gValid, gLast;
  logic signed [17:0] gRe, gIm;

  always #2.5 clk = ~clk;

  rfft_unpack #(.N(N), .DATA_W(16), .COEF_W(16)) uut (
    .clk(clk), .rst(rst),
    .smpValid(smpValid), .smpData(smpData),
    .pkValid(pkValid), .pkRe(pkRe), .pkIm(pkIm), .pkLast(pkLast),
    .binValid(binValid), .binLast(binLast), .binRe(binRe), .binIm(binIm),
    .gValid(gValid), .gLast(gLast), .gRe(gRe), .gIm(gIm)
  );

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  bit running = 1'b0;
  bit done = 1'b0;
  string phase = "R4";

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic longint coefQ(input int k, input bit wantSin);
    real v;
    v = wantSin ? $sin(PI_R * k / N) : $cos(PI_R * k / N);
    v = v * 16384.0;
    return longint'($rtoi(v >= 0.0 ? v + 0.5 : v - 0.5));
  endfunction

  function automatic int rnd16();
    return int'($signed(16'($urandom())));
  endfunction

  // ---------------- reference model
  int curRe [N];
  int curIm [N];
  int binPos = 0;
  int gDueQ[$], gKQ[$];
  longint gReQ[$], gImQ[$];
  bit haveEven = 1'b0;
  int evenVal = 0;
  int pairCnt = 0;
  int pDueQ[$], pReQ[$], pImQ[$];
  bit pLastQ[$];

  task automatic closeFrame(input int edgeNo);
    for (int k = 0; k < N; k++) begin
      longint ar, ai, br, bi, x1r, x1i, x2r, x2i, c, s;
      int p;
      p = (N - k) % N;
      ar = curRe[k]; ai = curIm[k]; br = curRe[p]; bi = curIm[p];
      x1r = (ar + br) >>> 1;
      x1i = (ai - bi) >>> 1;
      x2r = (ai + bi) >>> 1;
      x2i = (br - ar) >>> 1;
      c = coefQ(k, 1'b0);
      s = coefQ(k, 1'b1);
      gDueQ.push_back(edgeNo + 2 + k);
      gKQ.push_back(k);
      gReQ.push_back(x1r + ((c * x2r + s * x2i) >>> 14));
      gImQ.push_back(x1i + ((c * x2i - s * x2r) >>> 14));
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst) begin
      if (binValid) begin
        curRe[binPos] = int'(binRe);
        curIm[binPos] = int'(binIm);
        if (binPos == N - 1) begin
          closeFrame(cyc);
          binPos = 0;
        end else if (binLast) begin
          binPos = 0;
        end else begin
          binPos++;
        end
      end
      if (smpValid) begin
        if (!haveEven) begin
          evenVal = int'(smpData);
          haveEven = 1'b1;
        end else begin
          pDueQ.push_back(cyc);
          pReQ.push_back(evenVal);
          pImQ.push_back(int'(smpData));
          pLastQ.push_back(pairCnt == N - 1);
          pairCnt = (pairCnt + 1) % N;
          haveEven = 1'b0;
        end
      end
    end
  end

  // ---------------- per-cycle comparison
  always @(negedge clk) begin
    if (running && !rst) begin
      if (gDueQ.size() > 0 && gDueQ[0] == cyc) begin
        int k;
        string dreq;
        k = gKQ[0];
        dreq = (k == 0) ? "R5" : "R6";
        chk(gValid == 1'b1, phase, "gValid", gValid, 1);
        chk(longint'(gRe) == gReQ[0], dreq, $sformatf("gRe k=%0d", k), gRe, gReQ[0]);
        chk(longint'(gIm) == gImQ[0], dreq, $sformatf("gIm k=%0d", k), gIm, gImQ[0]);
        chk(gLast == (k == N - 1), "R4", "gLast", gLast, (k == N - 1));
        void'(gDueQ.pop_front()); void'(gKQ.pop_front());
        void'(gReQ.pop_front()); void'(gImQ.pop_front());
      end else begin
        chk(gValid == 1'b0, phase, "gValid idle", gValid, 0);
      end
      if (pDueQ.size() > 0 && pDueQ[0] == cyc) begin
        chk(pkValid == 1'b1, "R1", "pkValid", pkValid, 1);
        chk(int'(pkRe) == pReQ[0], "R1", "pkRe", pkRe, pReQ[0]);
        chk(int'(pkIm) == pImQ[0], "R1", "pkIm", pkIm, pImQ[0]);
        chk(pkLast == pLastQ[0], "R1", "pkLast", pkLast, pLastQ[0]);
        void'(pDueQ.pop_front()); void'(pReQ.pop_front());
        void'(pImQ.pop_front()); void'(pLastQ.pop_front());
      end else begin
        chk(pkValid == 1'b0, "R1", "pkValid idle", pkValid, 0);
      end
    end
  end

  // ---------------- stimulus tasks
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      binValid = 1'b0; binLast = 1'b0; smpValid = 1'b0;
    end
  endtask

  // mode 0: random, 1: full-scale extremes, 2: structured ramp
  task automatic sendFrame(input int mode, input bit gaps);
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      binValid = 1'b1;
      binLast  = (k == N - 1);
      case (mode)
        0: begin binRe = 16'(rnd16()); binIm = 16'(rnd16()); end
        1: begin
             binRe = ($urandom() % 2) ? 16'sh7FFF : 16'sh8000;
             binIm = ($urandom() % 2) ? 16'sh7FFF : 16'sh8000;
           end
        default: begin binRe = 16'(1000 + 37 * k); binIm = 16'(200 - 51 * k); end
      endcase
      if (gaps && (k % 3 == 1)) begin
        @(negedge clk);
        binValid = 1'b0; binLast = 1'b0;
      end
    end
  endtask

  task automatic sendShort(input int len);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      binValid = 1'b1;
      binLast  = (k == len - 1);
      binRe = 16'(rnd16()); binIm = 16'(rnd16());
    end
  endtask

  task automatic sendSamples(input int count, input bit gaps);
    for (int i = 0; i < count; i++) begin
      @(negedge clk);
      smpValid = 1'b1;
      smpData  = 16'(rnd16());
      if (gaps && (i % 4 == 2)) begin
        @(negedge clk);
        smpValid = 1'b0;
      end
    end
  endtask

  // ---------------- watchdog
  always @(posedge clk) begin
    if (cyc == WD_LIMIT && !done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL R4 watchdog actual=%0d expected=%0d", cyc, WD_LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  // ---------------- main sequence
  initial begin
    repeat (3) @(negedge clk);
    chk(gValid == 1'b0, "R8", "gValid in reset", gValid, 0);
    chk(gLast == 1'b0, "R8", "gLast in reset", gLast, 0);
    chk(pkValid == 1'b0, "R8", "pkValid in reset", pkValid, 0);
    chk(pkLast == 1'b0, "R8", "pkLast in reset", pkLast, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(gValid == 1'b0 && pkValid == 1'b0, "R8", "outputs after reset", gValid | pkValid, 0);
    running = 1'b1;

    phase = "R1";
    sendSamples(2 * N, 1'b0);
    sendSamples(4 * N, 1'b1);
    idle(4);

    phase = "R5";
    sendFrame(2, 1'b0);
    idle(N + 4);

    phase = "R2";
    sendFrame(0, 1'b1);
    idle(N + 4);

    phase = "R6";
    sendFrame(1, 1'b0);
    idle(N + 4);
    sendFrame(0, 1'b0);
    idle(N + 4);

    phase = "R3";
    sendShort(5);
    idle(N + 4);
    sendShort(1);
    sendFrame(0, 1'b0);
    idle(N + 4);

    phase = "R7";
    sendFrame(0, 1'b0);
    sendFrame(1, 1'b0);
    sendFrame(2, 1'b0);
    sendFrame(0, 1'b1);
    idle(N + 6);

    phase = "R4";
    sendFrame(0, 1'b0);
    sendSamples(2 * N, 1'b1);
    idle(N + 6);

    chk(gDueQ.size() == 0, "R4", "outputs still owed", gDueQ.size(), 0);
    chk(pDueQ.size() == 0, "R1", "packed words still owed", pDueQ.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule